// File: doc/BRIEF.md
# Byte-Lane Static RAM Strobe Controller

This block sits between a synchronous request port and an asynchronous static RAM of 32768 words by 16 bits. Each accepted request moves one word. The controller captures the address, the write data and the two byte enables. It then sequences the RAM's active-low chip select, output enable, write strobe and the two byte-lane selects. Every phase lasts a whole number of clock cycles, and the cycle counts are parameters. The defaults suit a 100 MHz clock and the fastest RAM timing grade.

A write starts with chip select and the lane selects, with the write strobe still high. The strobe then falls. The controller waits until the RAM has released its outputs, and only then drives the selected byte lanes. It stops driving in the same cycle that the strobe rises. A read holds chip select, output enable and the lane selects low for the access count and registers the bus at the end of it. A one-cycle valid pulse comes with the data. After every access the chip is deselected for a turnaround count before the next request is taken. A request with no byte enabled is retired in a single cycle and touches no strobe.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and right after reset, every RAM strobe (chip select, output enable, write strobe, both lane selects) is high, `rd_valid` is low and `req_ready` is high.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the chip has been deselected for the whole turnaround, and then it returns high.
- R3: For a write, `mem_ce_n` and the selected lane selects go low `SETUP_CYC` cycles before `mem_we_n` falls. `mem_we_n` then stays low for exactly `WE_CYC` cycles. `mem_oe_n` stays high the whole time, and `mem_addr` holds the captured address while `mem_ce_n` is low.
- R4: `req_be` bit 0 enables data bits 7:0 through `mem_lb_n`, and bit 1 enables bits 15:8 through `mem_ub_n`. A disabled lane's select stays high, so the RAM keeps that byte unchanged.
- R5: The controller drives a selected lane with the write data only from `DRV_DLY` cycles after `mem_we_n` falls until `mem_we_n` rises. It releases the lane in the cycle where the strobe rises.
- R6: For a read, `mem_ce_n`, `mem_oe_n` and the selected lane selects are low for `RD_CYC` cycles while `mem_we_n` is high. In the next cycle `rd_valid` is high for one cycle, and `rd_data` holds the bus value for enabled lanes and zero for disabled lanes.
- R7: After each read or write, all strobes are high for `TURN_CYC` cycles before `req_ready` rises.
- R8: A request with `req_be` equal to 00 asserts no strobe. `req_ready` is low for exactly one cycle and leaves the RAM contents unchanged.
- R9: `mem_oe_n` and `mem_we_n` are never low in the same cycle, so the controller never drives the bus while the RAM may drive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| mem_addr | output | 15 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq | inout | 16 | Bidirectional RAM data bus |

## Verification
The bench uses a non-default parameter set, with a three-cycle write strobe and a two-cycle turnaround. This exposes any phase that is off by one cycle. Each phase miscount shows up as a strobe mismatch in the cycle-by-cycle comparison. A design that drove data too early, or kept driving after the strobe rose, would be caught by the bus-content check inside the RAM model and by the overlap check on output enable and write strobe. Single-lane writes followed by full-word reads would expose a design that tied the lanes together or wrote the disabled byte. All-zero byte enables on reads and writes would reveal a stray strobe or a ready that stays low too long.

// File: rtl/sramc_pkg.sv
package sramc_pkg;
   typedef enum logic [2:0] {
      SC_IDLE  = 3'd0,
      SC_NULL  = 3'd1,
      SC_WSET  = 3'd2,
      SC_WSTB  = 3'd3,
      SC_RACC  = 3'd4,
      SC_TURN  = 3'd5
   } sc_state_e;

   function automatic int sc_max4(int a, int b, int c, int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/sramc_phase_cnt.sv
module sramc_phase_cnt #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic [CW-1:0] cnt,
   output logic          zero
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (!zero)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
   import sramc_pkg::*;
#(
   parameter int SETUP_CYC = 1,
   parameter int WE_CYC    = 2,
   parameter int DRV_DLY   = 1,
   parameter int RD_CYC    = 2,
   parameter int TURN_CYC  = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      req_write,
   input  logic      be_any,
   output sc_state_e state,
   output logic      accept,
   output logic      drive,
   output logic      cap
);
   localparam int MAXC = sc_max4(SETUP_CYC, WE_CYC, RD_CYC, TURN_CYC);
   localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
   localparam logic [CW-1:0] SET_L  = CW'(SETUP_CYC - 1);
   localparam logic [CW-1:0] WE_L   = CW'(WE_CYC - 1);
   localparam logic [CW-1:0] RD_L   = CW'(RD_CYC - 1);
   localparam logic [CW-1:0] TURN_L = CW'(TURN_CYC - 1);
   localparam logic [CW-1:0] DRV_L  = CW'(WE_CYC - 1 - DRV_DLY);

   sc_state_e       nxt;
   logic            ld;
   logic [CW-1:0]   ld_val;
   logic [CW-1:0]   cnt;
   logic            zero;

   sramc_phase_cnt #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .cnt      (cnt),
      .zero     (zero)
   );

   always_comb begin
      nxt    = state;
      ld     = 1'b0;
      ld_val = '0;
      unique case (state)
         SC_IDLE: begin
            if (req_valid) begin
               if (!be_any) begin
                  nxt = SC_NULL;
               end else if (req_write) begin
                  nxt = SC_WSET; ld = 1'b1; ld_val = SET_L;
               end else begin
                  nxt = SC_RACC; ld = 1'b1; ld_val = RD_L;
               end
            end
         end
         SC_NULL: nxt = SC_IDLE;
         SC_WSET: if (zero) begin nxt = SC_WSTB; ld = 1'b1; ld_val = WE_L;   end
         SC_WSTB: if (zero) begin nxt = SC_TURN; ld = 1'b1; ld_val = TURN_L; end
         SC_RACC: if (zero) begin nxt = SC_TURN; ld = 1'b1; ld_val = TURN_L; end
         SC_TURN: if (zero) nxt = SC_IDLE;
         default: nxt = SC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= SC_IDLE;
      else
         state <= nxt;
   end

   assign accept = (state == SC_IDLE) && req_valid;
   assign drive  = (state == SC_WSTB) && (cnt <= DRV_L);
   assign cap    = (state == SC_RACC) && zero;

   // R3
   strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SC_WSTB && zero) |=> (state == SC_TURN));
   // R8
   null_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SC_NULL) |=> (state == SC_IDLE));
endmodule

// File: rtl/sramc_lanes.sv
module sramc_lanes #(
   parameter int DW = 16,
   parameter int LW = 8,
   localparam int NL = DW / LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          drive,
   input  logic          cap,
   input  logic [NL-1:0] be,
   input  logic [DW-1:0] wdata,
   output logic [NL-1:0] sel_n,
   inout  wire  [DW-1:0] dq,
   output logic [DW-1:0] rdata
);
   for (genvar g = 0; g < NL; g++) begin : g_lane
      assign sel_n[g] = !(active && be[g]);
      assign dq[g*LW +: LW] = (drive && be[g]) ? wdata[g*LW +: LW] : {LW{1'bz}};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata[g*LW +: LW] <= '0;
         else if (cap)
            rdata[g*LW +: LW] <= be[g] ? dq[g*LW +: LW] : '0;
      end

      // R4
      lane_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (drive && be[g]) |-> !sel_n[g]);
   end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sramc_pkg::*;
#(
   parameter int AW        = 15,
   parameter int SETUP_CYC = 1,
   parameter int WE_CYC    = 2,
   parameter int DRV_DLY   = 1,
   parameter int RD_CYC    = 2,
   parameter int TURN_CYC  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [15:0]   req_wdata,
   input  logic [1:0]    req_be,
   output logic [15:0]   rd_data,
   output logic          rd_valid,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic          mem_lb_n,
   output logic          mem_ub_n,
   inout  wire  [15:0]   mem_dq
);
   localparam int DW = 16;
   localparam int NL = DW / 8;

   initial begin
      param_setup_chk: assert (SETUP_CYC >= 1);
      param_we_chk:    assert (WE_CYC >= 1 && DRV_DLY >= 0 && DRV_DLY < WE_CYC);
      param_rd_chk:    assert (RD_CYC >= 1);
      param_turn_chk:  assert (TURN_CYC >= 1);
      param_aw_chk:    assert (AW >= 1 && AW <= 24);
   end

   sc_state_e       state;
   logic            accept;
   logic            drive;
   logic            cap;
   logic            active;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   wdata_q;
   logic [NL-1:0]   be_q;
   logic [NL-1:0]   sel_n;

   sramc_seq #(
      .SETUP_CYC (SETUP_CYC),
      .WE_CYC    (WE_CYC),
      .DRV_DLY   (DRV_DLY),
      .RD_CYC    (RD_CYC),
      .TURN_CYC  (TURN_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .be_any    (|req_be),
      .state     (state),
      .accept    (accept),
      .drive     (drive),
      .cap       (cap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         be_q    <= req_be;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_valid <= 1'b0;
      else
         rd_valid <= cap;
   end

   assign active = (state == SC_WSET) || (state == SC_WSTB) || (state == SC_RACC);

   sramc_lanes #(.DW(DW), .LW(8)) u_lanes (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .drive  (drive),
      .cap    (cap),
      .be     (be_q),
      .wdata  (wdata_q),
      .sel_n  (sel_n),
      .dq     (mem_dq),
      .rdata  (rd_data)
   );

   assign req_ready = (state == SC_IDLE);
   assign mem_addr  = addr_q;
   assign mem_ce_n  = !active;
   assign mem_we_n  = (state != SC_WSTB);
   assign mem_oe_n  = (state != SC_RACC);
   assign mem_lb_n  = sel_n[0];
   assign mem_ub_n  = sel_n[1];

   // R9
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));
   // R5
   drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (!mem_we_n && mem_oe_n));
   // R3
   we_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && !(mem_lb_n && mem_ub_n)));
   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
   // R2
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready);
   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   // R7
   turn_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ce_n) |-> !req_ready);
endmodule

// File: tb/tb_sram_strobe_ctrl.sv
module tb_sram_strobe_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int S_C = 1;
   localparam int W_C = 3;
   localparam int D_C = 1;
   localparam int R_C = 2;
   localparam int T_C = 2;

   typedef struct packed {
      logic        ce, oe, we, lb, ub, rdy, rv;
      logic [15:0] rdata;
      logic [3:0]  tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   wire         req_ready;
   wire  [15:0] rd_data;
   wire         rd_valid;
   wire  [14:0] mem_addr;
   wire         mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
   wire  [15:0] mem_dq;

   int n_chk = 0;
   int n_err = 0;
   exp_t q[$];
   logic [15:0] ram [int];
   logic [15:0] refm [int];
   logic [14:0] cur_addr;
   logic [15:0] cur_wdata;
   logic [1:0]  cur_be;

   logic        ram_oe_q = 1'b0;
   logic [15:0] ram_rd = '0;
   logic        prev_we = 1'b1;
   int          we_k = 0;
   logic [15:0] pend = '0;
   logic [1:0]  pend_be = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_strobe_ctrl #(
      .AW(15), .SETUP_CYC(S_C), .WE_CYC(W_C), .DRV_DLY(D_C), .RD_CYC(R_C), .TURN_CYC(T_C)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
      .mem_dq(mem_dq)
   );

   wire ram_en = ram_oe_q && !mem_ce_n && !mem_oe_n && mem_we_n;
   assign mem_dq[7:0]  = (ram_en && !mem_lb_n) ? ram_rd[7:0]  : 8'bz;
   assign mem_dq[15:8] = (ram_en && !mem_ub_n) ? ram_rd[15:8] : 8'bz;

   function automatic logic [15:0] seed_val(int a);
      return 16'(a * 40503) ^ 16'h3C5A;
   endfunction

   function automatic logic [15:0] ram_get(int a);
      if (ram.exists(a)) return ram[a];
      return seed_val(a);
   endfunction

   function automatic logic [15:0] ref_get(int a);
      if (refm.exists(a)) return refm[a];
      return seed_val(a);
   endfunction

   function automatic string tag_name(logic [3:0] t);
      case (t)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         4'd7: return "R7";
         4'd8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, expv, $time);
      end
   endtask

   // Behavioural RAM: latches lanes during the strobe, commits when it ends
   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_oe_n && !mem_we_n)
            check(1'b0, "R9", "oe and we both low", 32'(mem_oe_n), 32'd1);
         if (!mem_ce_n && !mem_we_n) begin
            if (we_k >= D_C) begin
               if (!mem_lb_n)
                  check(mem_dq[7:0] == cur_wdata[7:0], "R5", "low lane data",
                        32'(mem_dq[7:0]), 32'(cur_wdata[7:0]));
               if (!mem_ub_n)
                  check(mem_dq[15:8] == cur_wdata[15:8], "R5", "high lane data",
                        32'(mem_dq[15:8]), 32'(cur_wdata[15:8]));
            end
            we_k++;
            pend    = mem_dq;
            pend_be = {!mem_ub_n, !mem_lb_n};
         end else if (!prev_we && mem_we_n) begin
            check(we_k >= W_C, "R3", "strobe overlap length", 32'(we_k), 32'(W_C));
            begin
               logic [15:0] w;
               w = ram_get(int'(mem_addr));
               if (pend_be[0]) w[7:0]  = pend[7:0];
               if (pend_be[1]) w[15:8] = pend[15:8];
               ram[int'(mem_addr)] = w;
            end
            we_k = 0;
         end
         prev_we  = mem_we_n;
         ram_rd   = ram_get(int'(mem_addr));
         ram_oe_q = !mem_ce_n && !mem_oe_n && mem_we_n;
      end
   end

   task automatic tick();
      exp_t e;
      @(negedge clk);
      if (q.size() > 0) e = q.pop_front();
      else e = '{ce:1, oe:1, we:1, lb:1, ub:1, rdy:1, rv:0, rdata:'0, tag:4'd2};
      check({mem_ce_n, mem_oe_n, mem_we_n} == {e.ce, e.oe, e.we}, tag_name(e.tag),
            "ce/oe/we", 32'({mem_ce_n, mem_oe_n, mem_we_n}), 32'({e.ce, e.oe, e.we}));
      check({mem_ub_n, mem_lb_n} == {e.ub, e.lb}, "R4", "lane selects",
            32'({mem_ub_n, mem_lb_n}), 32'({e.ub, e.lb}));
      check(req_ready == e.rdy, (e.tag == 4'd8) ? "R8" : "R2", "ready",
            32'(req_ready), 32'(e.rdy));
      check(rd_valid == e.rv, "R6", "rd_valid", 32'(rd_valid), 32'(e.rv));
      if (e.rv)
         check(rd_data == e.rdata, "R6", "rd_data", 32'(rd_data), 32'(e.rdata));
      if (!e.ce)
         check(mem_addr == cur_addr, "R3", "address", 32'(mem_addr), 32'(cur_addr));
   endtask

   task automatic push(logic ce, logic oe, logic we, logic lb, logic ub,
                       logic rdy, logic rv, logic [15:0] rd, logic [3:0] t);
      exp_t e;
      e = '{ce:ce, oe:oe, we:we, lb:lb, ub:ub, rdy:rdy, rv:rv, rdata:rd, tag:t};
      q.push_back(e);
   endtask

   task automatic do_req(input bit wr, input logic [14:0] a, input logic [15:0] d,
                         input logic [1:0] be);
      logic [15:0] r;
      cur_addr = a; cur_wdata = d; cur_be = be;
      if (be == 2'b00) begin
         push(1, 1, 1, 1, 1, 0, 0, '0, 4'd8);
      end else if (wr) begin
         for (int i = 0; i < S_C; i++) push(0, 1, 1, !be[0], !be[1], 0, 0, '0, 4'd3);
         for (int i = 0; i < W_C; i++) push(0, 1, 0, !be[0], !be[1], 0, 0, '0, 4'd3);
         for (int i = 0; i < T_C; i++) push(1, 1, 1, 1, 1, 0, 0, '0, 4'd7);
         r = ref_get(int'(a));
         if (be[0]) r[7:0]  = d[7:0];
         if (be[1]) r[15:8] = d[15:8];
         refm[int'(a)] = r;
      end else begin
         r = ref_get(int'(a));
         if (!be[0]) r[7:0]  = 8'h00;
         if (!be[1]) r[15:8] = 8'h00;
         for (int i = 0; i < R_C; i++) push(0, 0, 1, !be[0], !be[1], 0, 0, '0, 4'd6);
         for (int i = 0; i < T_C; i++) push(1, 1, 1, 1, 1, 0, (i == 0), r, 4'd7);
      end
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      tick();
      req_valid = 1'b0; req_wdata = ~d;
      while (q.size() > 0) tick();
      tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int x;
      repeat (3) @(negedge clk);
      // R1: values held in reset
      check({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} == 5'h1F, "R1", "strobes in reset",
            32'({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}), 32'h1F);
      check(!rd_valid && req_ready, "R1", "valid/ready in reset",
            32'({rd_valid, req_ready}), 32'b01);
      rst_n = 1'b1;
      tick();
      tick();
      // R3 R5 full word write, R6 full read
      do_req(1, 15'h0005, 16'hA1B2, 2'b11);
      do_req(0, 15'h0005, 16'h0000, 2'b11);
      // R4 single-lane writes keep the other byte
      do_req(1, 15'h0005, 16'hFFFF, 2'b01);
      do_req(0, 15'h0005, 16'h0000, 2'b11);
      do_req(1, 15'h0005, 16'h3C00, 2'b10);
      do_req(0, 15'h0005, 16'h0000, 2'b11);
      // R6 disabled lane reads as zero
      do_req(0, 15'h0005, 16'h0000, 2'b01);
      do_req(0, 15'h0005, 16'h0000, 2'b10);
      // R8 empty byte enables
      do_req(1, 15'h0005, 16'h1234, 2'b00);
      do_req(0, 15'h0005, 16'h0000, 2'b00);
      do_req(0, 15'h0005, 16'h0000, 2'b11);
      // address extremes, untouched word, R7 turnaround between back-to-back ops
      do_req(1, 15'h7FFF, 16'h8001, 2'b11);
      do_req(1, 15'h0000, 16'h7FFE, 2'b11);
      do_req(0, 15'h7FFF, 16'h0000, 2'b11);
      do_req(0, 15'h0000, 16'h0000, 2'b11);
      do_req(0, 15'h0123, 16'h0000, 2'b11);
      x = 7;
      for (int i = 0; i < 60; i++) begin
         x = x * 1103515245 + 12345;
         do_req(x[16], {12'h000, x[20:18]}, x[15:0] ^ 16'(i), x[22:21]);
      end
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule